// File: doc/BRIEF.md
# Quad Down-Counting Timer

This block holds four independent down-counters behind one small register bus. Software writes each channel's start value, background reload value and control word, and reads its live count at any time. Each channel counts external tick-enable pulses through its own prescaler. A channel stops once and clears its own enable, wraps to all-ones, or reloads from its background register, as its control word selects. It can count with 32 bits or with only the low 16.

Every channel that passes zero sets its own bit in a shared raw status register. Software clears that bit by writing a 1 to the clear register. A mask register selects which raw bits reach the masked status and the single interrupt output. One clock drives both the bus and the counters. The tick-enable input sets the count rate.

Top module: `quad_dntimer`

## Requirements
- R1: After reset every register reads zero, every channel is disabled and `irq_o` is low.
- R2: Byte addresses must be word aligned (bits 1:0 zero). Shared registers: mask at 0x00, raw status at 0x04, masked status at 0x08, clear at 0x0C. Channel n (0..3) starts at 0x10+0x10*n, with load at +0x0, current count at +0x4, control at +0x8 and background load at +0xC. A load write sets the count in the same cycle it is accepted.
- R3: A channel changes its count only in a cycle where it is enabled (control bit 7) and `tick_en` is high (after prescaling). Otherwise the count holds, and the count read back is the bitwise inverse of the elapsed ticks when counting starts from all-ones.
- R4: In free-running mode (control bit 6 = 0, bit 0 = 0), a decrement from 0 wraps to the all-ones value of the selected width and sets the channel's raw status bit.
- R5: In periodic mode (bit 6 = 1, bit 0 = 0), a decrement from 0 loads the background value and sets the raw bit. Writing the background register does not change the current count.
- R6: In one-shot mode (bit 0 = 1), a decrement from 0 leaves the count at 0, sets the raw bit and clears control bit 7, so no further ticks are counted.
- R7: With control bit 1 = 0, only the low 16 bits count and wrap, and bits 31:16 of the count read as zero.
- R8: Control bits 3:2 select the prescale. 00 gives one decrement per tick, 01 one per 16 ticks, and 10 or 11 one per 256 ticks.
- R9: A write to a channel's control or load register restarts its prescaler, so a full prescale period of ticks is needed before the next decrement.
- R10: Raw status bit n belongs to channel n. Writing 1 to bit n of the clear register clears it. An underflow in the same cycle as the clear wins, and the bit stays set.
- R11: Masked status equals raw status AND the mask register, and `irq_o` is the OR of the four masked bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for bus and counters |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-rate pulse, one tick per high cycle |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is an underflow landing in the same cycle as a write of 1 to the clear register. The bench parks a channel at zero through a load write, then raises `tick_en` in the very cycle the clear write is accepted. The prescaler windows are the other fragile area. The bench gives exactly one tick less than a full window, then one more, and also restarts the window mid-way with a control or load write.

// File: rtl/qtim_pkg.sv
// Package: shared sizes and control-word bit positions for the quad timer.
// Assumes a 32-bit data path and four channels.
package qtim_pkg;
    localparam int NUM_CH  = 4;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int CTRL_W  = 8;
    localparam int PRE_W   = 8;

    // Control word bit positions (software visible)
    localparam int C_EN    = 7;
    localparam int C_PER   = 6;
    localparam int C_PSHI  = 3;
    localparam int C_PSLO  = 2;
    localparam int C_WIDE  = 1;
    localparam int C_ONCE  = 0;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'hCF;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_ALT256 = 2'b11
    } presc_e;

    // Register slot inside a channel's 16-byte window
    typedef enum logic [1:0] {
        SLOT_LOAD = 2'b00,
        SLOT_CNT  = 2'b01,
        SLOT_CTRL = 2'b10,
        SLOT_BG   = 2'b11
    } slot_e;
endpackage

// File: rtl/qtim_prescaler.sv
// Module: tick prescaler for one channel.
// It counts tick pulses while the channel runs and emits one step per 1, 16 or
// 256 ticks. A clear input restarts the window. It assumes tick_i lasts one cycle per tick.
module qtim_prescaler
    import qtim_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       step_o
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] lim;

    // Terminal count for the selected division
    always_comb begin
        case (presc_e'(sel_i))
            PS_DIV1:  lim = '0;
            PS_DIV16: lim = PW'(15);
            default:  lim = PW'(255);
        endcase
    end

    assign step_o = run_i && tick_i && (cnt == lim);

    // Tick counter; restarts on clear or at the end of the window
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clr_i)         cnt <= '0;
        else if (run_i && tick_i) cnt <= (cnt == lim) ? '0 : cnt + PW'(1);
    end

    // R8
    step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (tick_i && run_i));
    // R9
    clr_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt == '0));
endmodule

// File: rtl/qtim_channel.sv
// Module: one down-counting channel with load, background load and control.
// It decrements on each prescaled step. At zero it stops, wraps or reloads,
// as the control word says, and pulses uflow_o. It assumes at most one register write per cycle.
module qtim_channel
    import qtim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_we,
    input  logic              ctrl_we,
    input  logic              bg_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] bg_q,
    output logic              uflow_o
);
    logic [DATA_W-1:0] load_r, cnt_r, bg_r;
    logic [CTRL_W-1:0] ctrl_r;
    logic              step, wide, at_zero;
    logic [DATA_W-1:0] cnt_vis;

    assign wide    = ctrl_r[C_WIDE];
    assign cnt_vis = wide ? cnt_r : {{HALF_W{1'b0}}, cnt_r[HALF_W-1:0]};
    assign at_zero = (cnt_vis == '0);

    qtim_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .run_i  (ctrl_r[C_EN]),
        .clr_i  (ctrl_we || load_we),
        .sel_i  (ctrl_r[C_PSHI:C_PSLO]),
        .step_o (step)
    );

    assign uflow_o = step && at_zero && !load_we;

    // Register file and counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_r <= '0;
            cnt_r  <= '0;
            bg_r   <= '0;
            ctrl_r <= '0;
        end else begin
            if (bg_we) bg_r <= wdata;
            if (ctrl_we)
                ctrl_r <= wdata[CTRL_W-1:0] & CTRL_WMASK;
            else if (uflow_o && ctrl_r[C_ONCE])
                ctrl_r[C_EN] <= 1'b0;
            if (load_we) begin
                load_r <= wdata;
                cnt_r  <= wdata;
            end else if (step) begin
                if (!at_zero)
                    cnt_r <= wide ? cnt_r - DATA_W'(1)
                                  : {{HALF_W{1'b0}}, cnt_r[HALF_W-1:0] - HALF_W'(1)};
                else if (ctrl_r[C_ONCE])
                    cnt_r <= '0;
                else if (ctrl_r[C_PER])
                    cnt_r <= wide ? bg_r : {{HALF_W{1'b0}}, bg_r[HALF_W-1:0]};
                else
                    cnt_r <= wide ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            end
        end
    end

    assign load_q = load_r;
    assign cnt_q  = cnt_vis;
    assign ctrl_q = {{(DATA_W-CTRL_W){1'b0}}, ctrl_r};
    assign bg_q   = bg_r;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_i && ctrl_r[C_EN]) && !load_we) |=> $stable(cnt_r));
    // R6
    oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow_o && ctrl_r[C_ONCE] && !ctrl_we) |=> (!ctrl_r[C_EN] && cnt_vis == '0));
    // R7
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_r[C_WIDE] |-> (cnt_q[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/qtim_irq.sv
// Module: shared raw status, mask, masked status and combined interrupt.
// The set inputs are one-cycle underflow pulses. A set beats a clear that arrives in the same cycle.
module qtim_irq
    import qtim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] mis_q,
    output logic              irq_o
);
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    // Raw status: clear by write-one, set by underflow (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_bits) | set_i;
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wbits;
    end

    assign mis_q = raw_q & mask_q;
    assign irq_o = |mis_q;

    // R10
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));
    // R10
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_i == '0) |=> ((raw_q & $past(wbits)) == '0));
endmodule

// File: rtl/quad_dntimer.sv
// Module: top of the quad down-counting timer.
// It decodes the register bus, instantiates four channels and the shared interrupt logic,
// and muxes the read data. It assumes one clock for bus and counters and aligned word accesses.
module quad_dntimer
    import qtim_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0]  blk;
    logic [1:0]        slot;
    logic              aligned;
    logic              shared_hit;
    logic [NUM_CH-1:0] uflow;
    logic [NUM_CH-1:0] raw, mask, mis;
    logic [DATA_W-1:0] ch_load [NUM_CH];
    logic [DATA_W-1:0] ch_cnt  [NUM_CH];
    logic [DATA_W-1:0] ch_ctrl [NUM_CH];
    logic [DATA_W-1:0] ch_bg   [NUM_CH];

    assign blk        = bus_addr[ADDR_W-1:4];
    assign slot       = bus_addr[3:2];
    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign shared_hit = aligned && (blk == '0);

    // Per-channel instances with their own write decode
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic hit;
        assign hit = aligned && (blk == BLK_W'(n + 1));
        qtim_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_en),
            .load_we (bus_wr && hit && slot == SLOT_LOAD),
            .ctrl_we (bus_wr && hit && slot == SLOT_CTRL),
            .bg_we   (bus_wr && hit && slot == SLOT_BG),
            .wdata   (bus_wdata),
            .load_q  (ch_load[n]),
            .cnt_q   (ch_cnt[n]),
            .ctrl_q  (ch_ctrl[n]),
            .bg_q    (ch_bg[n]),
            .uflow_o (uflow[n])
        );
    end

    qtim_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (uflow),
        .mask_we (bus_wr && shared_hit && slot == 2'd0),
        .clr_we  (bus_wr && shared_hit && slot == 2'd3),
        .wbits   (bus_wdata[NUM_CH-1:0]),
        .raw_q   (raw),
        .mask_q  (mask),
        .mis_q   (mis),
        .irq_o   (irq_o)
    );

    // Read data mux, zero when no read strobe or no hit
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && shared_hit) begin
            case (slot)
                2'd0:    bus_rdata = DATA_W'(mask);
                2'd1:    bus_rdata = DATA_W'(raw);
                2'd2:    bus_rdata = DATA_W'(mis);
                default: bus_rdata = '0;
            endcase
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (bus_rd && aligned && blk == BLK_W'(n + 1)) begin
                case (slot_e'(slot))
                    SLOT_LOAD: bus_rdata = ch_load[n];
                    SLOT_CNT:  bus_rdata = ch_cnt[n];
                    SLOT_CTRL: bus_rdata = ch_ctrl[n];
                    default:   bus_rdata = ch_bg[n];
                endcase
            end
        end
    end

    // R11
    irq_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((raw & mask) != '0));
    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && raw == '0));
endmodule

// File: tb/test_quad_dntimer.sv
// Directed bench: one task per scenario, each checking its own results.
module test_quad_dntimer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    quad_dntimer i_quad_dntimer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One write, accepted at the next rising edge; optional tick in the same cycle
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic quiesce();
        for (int c = 0; c < 4; c++) wr(8'(8'h18 + 16 * c), 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'hF);
    endtask

    task automatic t_reset();
        chk_reg("R1", 8'h00, 0); chk_reg("R1", 8'h04, 0); chk_reg("R1", 8'h08, 0);
        chk_reg("R1", 8'h14, 0); chk_reg("R1", 8'h18, 0); chk_reg("R1", 8'h1C, 0);
        chk_reg("R1", 8'h48, 0);
        check("R1", {31'b0, irq_o}, 0);
    endtask

    task automatic t_load_disabled();
        wr(8'h10, 32'h55);
        chk_reg("R2", 8'h14, 32'h55);
        chk_reg("R2", 8'h10, 32'h55);
        wr(8'h1C, 32'h77);
        chk_reg("R2", 8'h1C, 32'h77);
        chk_reg("R2", 8'h15, 32'h0);  // unaligned reads as zero
        ticks(5);
        chk_reg("R3", 8'h14, 32'h55);  // disabled channel holds
    endtask

    task automatic t_free();
        logic [31:0] v;
        quiesce();
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h18, 32'h82);
        chk_reg("R2", 8'h18, 32'h82);
        ticks(7);
        rd(8'h14, v);
        check("R3", ~v, 32'd7);        // inverse gives elapsed ticks
        repeat (6) @(negedge clk);
        chk_reg("R3", 8'h14, ~32'd7); // no tick, no change
        wr(8'h10, 32'd5);
        ticks(3);
        chk_reg("R4", 8'h14, 32'd2);
        ticks(3);
        chk_reg("R4", 8'h14, 32'hFFFF_FFFF);
        chk_reg("R4", 8'h04, 32'h1);
        wr(8'h0C, 32'h1);
        chk_reg("R10", 8'h04, 32'h0);
    endtask

    task automatic t_periodic();
        quiesce();
        wr(8'h20, 32'd2);
        wr(8'h2C, 32'd7);
        wr(8'h28, 32'hC2);
        ticks(1);
        wr(8'h2C, 32'd9);
        chk_reg("R5", 8'h24, 32'd1);   // background write leaves count alone
        ticks(2);
        chk_reg("R5", 8'h24, 32'd9);
        chk_reg("R5", 8'h04, 32'h2);
        ticks(1);
        chk_reg("R5", 8'h24, 32'd8);
    endtask

    task automatic t_oneshot();
        quiesce();
        wr(8'h30, 32'd1);
        wr(8'h38, 32'h83);
        ticks(2);
        chk_reg("R6", 8'h34, 32'd0);
        chk_reg("R6", 8'h38, 32'h03);
        chk_reg("R6", 8'h04, 32'h4);
        wr(8'h0C, 32'h4);
        ticks(3);
        chk_reg("R6", 8'h34, 32'd0);
        chk_reg("R6", 8'h04, 32'h0);
    endtask

    task automatic t_narrow();
        quiesce();
        wr(8'h40, 32'h1234_0001);
        wr(8'h48, 32'h80);
        chk_reg("R7", 8'h44, 32'h1);
        ticks(2);
        chk_reg("R7", 8'h44, 32'h0000_FFFF);
        chk_reg("R7", 8'h04, 32'h8);
    endtask

    task automatic t_presc();
        quiesce();
        wr(8'h10, 32'd10);
        wr(8'h18, 32'h86);
        ticks(15); chk_reg("R8", 8'h14, 32'd10);
        ticks(1);  chk_reg("R8", 8'h14, 32'd9);
        wr(8'h18, 32'h8A);
        ticks(255); chk_reg("R8", 8'h14, 32'd9);
        ticks(1);   chk_reg("R8", 8'h14, 32'd8);
        wr(8'h18, 32'h8E);
        ticks(255); chk_reg("R8", 8'h14, 32'd8);
        ticks(1);   chk_reg("R8", 8'h14, 32'd7);
        wr(8'h18, 32'h86);
        ticks(10);
        wr(8'h18, 32'h86);
        ticks(15); chk_reg("R9", 8'h14, 32'd7);
        ticks(1);  chk_reg("R9", 8'h14, 32'd6);
        ticks(10);
        wr(8'h10, 32'd20);
        ticks(15); chk_reg("R9", 8'h14, 32'd20);
        ticks(1);  chk_reg("R9", 8'h14, 32'd19);
    endtask

    task automatic t_irq();
        quiesce();
        wr(8'h10, 32'd0);
        wr(8'h18, 32'h82);
        ticks(1);
        chk_reg("R10", 8'h04, 32'h1);
        chk_reg("R11", 8'h08, 32'h0);
        check("R11", {31'b0, irq_o}, 0);
        wr(8'h00, 32'h1);
        chk_reg("R11", 8'h08, 32'h1);
        check("R11", {31'b0, irq_o}, 1);
        wr(8'h00, 32'h2);
        check("R11", {31'b0, irq_o}, 0);
        wr(8'h00, 32'h1);
        wr(8'h0C, 32'h1);
        check("R11", {31'b0, irq_o}, 0);
        wr(8'h10, 32'd0);
        wr(8'h0C, 32'h1, 1'b1);        // underflow beats clear
        chk_reg("R10", 8'h04, 32'h1);
        check("R11", {31'b0, irq_o}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_disabled();
        t_free();
        t_periodic();
        t_oneshot();
        t_narrow();
        t_presc();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule